// File: doc/BRIEF.md
# ACPI event status and SCI generator

This block keeps the fixed power-management event status word, its matching enable word and a one-byte general-purpose event (GPE) status/enable pair. Hardware event pulses for the timer, bus master, global lock, power button, sleep button, RTC and wake sources set sticky status bits. A GPE raise vector sets GPE status bits that the validity mask allows. Software reads the registers over a simple I/O-port request bus. It clears status bits by writing ones and programs the enables.

The block drives a level-sensitive system control interrupt (`sci`). This line stays high while any interrupt-capable status bit is set together with its enable, or while any valid GPE bit is both active and enabled. The line is recomputed from register state after every change.

Each request receives a response one cycle later. The response carries the read data, or an error when the access size or the address is not legal. A rejected request changes no state.

Top module: `acpi_evt_sci`

## Requirements
- R1: After reset, the event status word, the event enable word, the GPE status byte and the GPE enable byte read as zero, `sci` is low, and `rsp_vld` stays low until a request arrives.
- R2: A one-cycle event pulse sets its sticky status bit, and the bit holds until software clears it. Bit positions: timer 0, bus master 4, global lock 5, power button 8, sleep button 9, RTC 10, wake 15.
- R3: A write to the status word clears only the wake (15), RTC (10), sleep (9), power (8) and bus-master (4) bits that are written as 1. Timer (0) and global-lock (5) bits ignore writes, and bits written as 0 are unchanged.
- R4: A write to the enable word stores only bit 10 (RTC), bit 8 (power) and bit 5 (global lock). Every other enable bit reads back as 0.
- R5: The status word (at `PM1_BASE`) and the enable word (at `PM1_BASE`+2) accept only 2-byte accesses. Any other size returns `rsp_err`=1 and leaves all state unchanged.
- R6: The GPE status (at `GPE_BASE`) and GPE enable (at `GPE_BASE`+1) accept only 1-byte accesses. A status write clears the bits written as 1 within the valid mask. An enable write stores the written byte ANDed with the valid mask (default mask 0x01).
- R7: `gpe_raise` sets GPE status bits only at valid-mask positions. A raise at any other position is ignored.
- R8: `sci` is high exactly when (status AND enable) is nonzero on bits 0, 5, 8, 9 or 10, or when (GPE status AND GPE enable) is nonzero. The output reflects each register change in the cycle after the edge that made the change.
- R9: An event pulse in the same cycle as a write-1-to-clear of the same bit leaves the bit set.
- R10: A power button pulse sets bit 8 only while `sci_en` is high. A pulse while `sci_en` is low is dropped.
- R11: Every request gets `rsp_vld` on the next cycle. An address that matches no register returns `rsp_err`=1, and a successful read returns the register value zero-extended to 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | 1 | Register request present this cycle |
| req_wr | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | I/O port address |
| req_size | input | 3 | Access size in bytes |
| req_wdata | input | 16 | Write data |
| rsp_vld | output | 1 | Response for the request of the previous cycle |
| rsp_err | output | 1 | Request rejected (size or address) |
| rsp_rdata | output | 16 | Read data, zero for writes and errors |
| ev_tmr | input | 1 | Timer event pulse |
| ev_bm | input | 1 | Bus master event pulse |
| ev_gbl | input | 1 | Global lock event pulse |
| ev_pwrbtn | input | 1 | Power button event pulse |
| ev_slpbtn | input | 1 | Sleep button event pulse |
| ev_rtc | input | 1 | RTC alarm event pulse |
| ev_wak | input | 1 | Wake event pulse |
| gpe_raise | input | GPE_W | GPE raise request, one bit per event |
| sci_en | input | 1 | Interrupt mode enabled by the control block |
| sci | output | 1 | Level system control interrupt |

## Verification
Status and enable registers change on the rising edge that samples an event pulse or a write. `sci` is a combinational function of those registers, so it is due one edge after the stimulus. A read response is registered on the edge that samples the request and shows the register contents from before that edge. The bench therefore drives every request or pulse on a falling edge and samples the response, `sci` and follow-up reads on the next falling edge. It never reads a register in the same cycle that it changes it.

// File: rtl/acpi_evt_pkg.sv
package acpi_evt_pkg;

    localparam int unsigned DATA_W = 16;

    // status / enable bit positions (decoded by system software)
    localparam int unsigned B_TMR    = 0;
    localparam int unsigned B_BM     = 4;
    localparam int unsigned B_GBL    = 5;
    localparam int unsigned B_PWRBTN = 8;
    localparam int unsigned B_SLPBTN = 9;
    localparam int unsigned B_RTC    = 10;
    localparam int unsigned B_WAK    = 15;

    localparam logic [DATA_W-1:0] STS_W1C_MASK =
        DATA_W'((1 << B_WAK) | (1 << B_RTC) | (1 << B_SLPBTN) | (1 << B_PWRBTN) | (1 << B_BM));
    localparam logic [DATA_W-1:0] EN_WR_MASK =
        DATA_W'((1 << B_RTC) | (1 << B_PWRBTN) | (1 << B_GBL));
    localparam logic [DATA_W-1:0] SCI_SRC_MASK =
        DATA_W'((1 << B_TMR) | (1 << B_GBL) | (1 << B_PWRBTN) | (1 << B_SLPBTN) | (1 << B_RTC));

    localparam logic [2:0] SIZE_WORD = 3'd2;
    localparam logic [2:0] SIZE_BYTE = 3'd1;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_PM1_STS,
        SEL_PM1_EN,
        SEL_GPE_STS,
        SEL_GPE_EN
    } reg_sel_e;

    typedef struct packed {
        logic tmr;
        logic bm;
        logic gbl;
        logic pwrbtn;
        logic slpbtn;
        logic rtc;
        logic wak;
    } pm1_ev_t;

endpackage

// File: rtl/acpi_reg_dec.sv
module acpi_reg_dec
    import acpi_evt_pkg::*;
#(
    parameter int unsigned        ADDR_W   = 16,
    parameter logic [ADDR_W-1:0]  PM1_BASE = 'h0400,
    parameter logic [ADDR_W-1:0]  GPE_BASE = 'h0420
) (
    input  logic              req_vld,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [2:0]        req_size,
    output reg_sel_e          sel,
    output logic              bad
);

    localparam logic [ADDR_W-1:0] PM1_EN_ADDR = PM1_BASE + ADDR_W'(2);
    localparam logic [ADDR_W-1:0] GPE_EN_ADDR = GPE_BASE + ADDR_W'(1);

    reg_sel_e sel_raw;
    logic     size_ok;

    always_comb begin
        sel_raw = SEL_NONE;
        size_ok = 1'b0;
        if (req_addr == PM1_BASE) begin
            sel_raw = SEL_PM1_STS;
            size_ok = (req_size == SIZE_WORD);
        end else if (req_addr == PM1_EN_ADDR) begin
            sel_raw = SEL_PM1_EN;
            size_ok = (req_size == SIZE_WORD);
        end else if (req_addr == GPE_BASE) begin
            sel_raw = SEL_GPE_STS;
            size_ok = (req_size == SIZE_BYTE);
        end else if (req_addr == GPE_EN_ADDR) begin
            sel_raw = SEL_GPE_EN;
            size_ok = (req_size == SIZE_BYTE);
        end
        sel = (req_vld && size_ok) ? sel_raw : SEL_NONE;
        bad = req_vld && !size_ok;
    end

endmodule

// File: rtl/acpi_pm1_regs.sv
module acpi_pm1_regs
    import acpi_evt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_sts,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  pm1_ev_t           ev,
    input  logic              pwr_gate,
    output logic [DATA_W-1:0] sts,
    output logic [DATA_W-1:0] en,
    output logic              pend
);

    typedef struct packed {
        logic [DATA_W-1:0] sts;
        logic [DATA_W-1:0] en;
    } pm1_st_t;

    pm1_st_t           st_d, st_q;
    logic [DATA_W-1:0] set_v;
    logic [DATA_W-1:0] clr_v;

    always_comb begin
        set_v           = '0;
        set_v[B_TMR]    = ev.tmr;
        set_v[B_BM]     = ev.bm;
        set_v[B_GBL]    = ev.gbl;
        set_v[B_PWRBTN] = ev.pwrbtn & pwr_gate;
        set_v[B_SLPBTN] = ev.slpbtn;
        set_v[B_RTC]    = ev.rtc;
        set_v[B_WAK]    = ev.wak;

        clr_v = wr_sts ? (wdata & STS_W1C_MASK) : '0;

        st_d     = st_q;
        // a new event wins over a same-cycle clear
        st_d.sts = (st_q.sts & ~clr_v) | set_v;
        if (wr_en) begin
            st_d.en = wdata & EN_WR_MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sts  = st_q.sts;
    assign en   = st_q.en;
    assign pend = |(st_q.sts & st_q.en & SCI_SRC_MASK);

endmodule

// File: rtl/acpi_gpe_regs.sv
module acpi_gpe_regs #(
    parameter int unsigned       GPE_W     = 8,
    parameter logic [GPE_W-1:0]  GPE_VALID = 'h01
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_sts,
    input  logic             wr_en,
    input  logic [GPE_W-1:0] wdata,
    input  logic [GPE_W-1:0] raise,
    output logic [GPE_W-1:0] sts,
    output logic [GPE_W-1:0] en,
    output logic             pend
);

    typedef struct packed {
        logic [GPE_W-1:0] sts;
        logic [GPE_W-1:0] en;
    } gpe_st_t;

    gpe_st_t          st_d, st_q;
    logic [GPE_W-1:0] clr_v;
    logic [GPE_W-1:0] hit;

    always_comb begin
        clr_v    = wr_sts ? (wdata & GPE_VALID) : '0;
        st_d     = st_q;
        st_d.sts = (st_q.sts & ~clr_v) | (raise & GPE_VALID);
        if (wr_en) begin
            st_d.en = wdata & GPE_VALID;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < GPE_W; g++) begin : g_hit
        if (GPE_VALID[g]) begin : g_live
            assign hit[g] = st_q.sts[g] & st_q.en[g];
        end else begin : g_dead
            assign hit[g] = 1'b0;
        end
    end

    assign sts  = st_q.sts;
    assign en   = st_q.en;
    assign pend = |hit;

endmodule

// File: rtl/acpi_evt_sci.sv
module acpi_evt_sci
    import acpi_evt_pkg::*;
#(
    parameter int unsigned        ADDR_W    = 16,
    parameter logic [ADDR_W-1:0]  PM1_BASE  = 'h0400,
    parameter logic [ADDR_W-1:0]  GPE_BASE  = 'h0420,
    parameter int unsigned        GPE_W     = 8,
    parameter logic [GPE_W-1:0]   GPE_VALID = 'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_vld,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [2:0]        req_size,
    input  logic [15:0]       req_wdata,
    output logic              rsp_vld,
    output logic              rsp_err,
    output logic [15:0]       rsp_rdata,
    input  logic              ev_tmr,
    input  logic              ev_bm,
    input  logic              ev_gbl,
    input  logic              ev_pwrbtn,
    input  logic              ev_slpbtn,
    input  logic              ev_rtc,
    input  logic              ev_wak,
    input  logic [GPE_W-1:0]  gpe_raise,
    input  logic              sci_en,
    output logic              sci
);

    typedef struct packed {
        logic              vld;
        logic              err;
        logic [DATA_W-1:0] data;
    } rsp_t;

    reg_sel_e          dec_sel;
    logic              dec_bad;
    logic              wr_pm1_sts, wr_pm1_en, wr_gpe_sts, wr_gpe_en;
    pm1_ev_t           ev;
    logic [DATA_W-1:0] pm1_sts, pm1_en;
    logic [GPE_W-1:0]  gpe_sts, gpe_en;
    logic              pm1_pend, gpe_pend;
    rsp_t              rsp_d, rsp_q;

    acpi_reg_dec #(
        .ADDR_W   (ADDR_W),
        .PM1_BASE (PM1_BASE),
        .GPE_BASE (GPE_BASE)
    ) u_dec (
        .req_vld  (req_vld),
        .req_addr (req_addr),
        .req_size (req_size),
        .sel      (dec_sel),
        .bad      (dec_bad)
    );

    assign wr_pm1_sts = req_wr && (dec_sel == SEL_PM1_STS);
    assign wr_pm1_en  = req_wr && (dec_sel == SEL_PM1_EN);
    assign wr_gpe_sts = req_wr && (dec_sel == SEL_GPE_STS);
    assign wr_gpe_en  = req_wr && (dec_sel == SEL_GPE_EN);

    assign ev.tmr    = ev_tmr;
    assign ev.bm     = ev_bm;
    assign ev.gbl    = ev_gbl;
    assign ev.pwrbtn = ev_pwrbtn;
    assign ev.slpbtn = ev_slpbtn;
    assign ev.rtc    = ev_rtc;
    assign ev.wak    = ev_wak;

    acpi_pm1_regs u_pm1 (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_sts   (wr_pm1_sts),
        .wr_en    (wr_pm1_en),
        .wdata    (req_wdata),
        .ev       (ev),
        .pwr_gate (sci_en),
        .sts      (pm1_sts),
        .en       (pm1_en),
        .pend     (pm1_pend)
    );

    acpi_gpe_regs #(
        .GPE_W     (GPE_W),
        .GPE_VALID (GPE_VALID)
    ) u_gpe (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_sts (wr_gpe_sts),
        .wr_en  (wr_gpe_en),
        .wdata  (req_wdata[GPE_W-1:0]),
        .raise  (gpe_raise),
        .sts    (gpe_sts),
        .en     (gpe_en),
        .pend   (gpe_pend)
    );

    always_comb begin
        rsp_d      = '0;
        rsp_d.vld  = req_vld;
        rsp_d.err  = dec_bad;
        if (!req_wr) begin
            unique case (dec_sel)
                SEL_PM1_STS: rsp_d.data = pm1_sts;
                SEL_PM1_EN:  rsp_d.data = pm1_en;
                SEL_GPE_STS: rsp_d.data = DATA_W'(gpe_sts);
                SEL_GPE_EN:  rsp_d.data = DATA_W'(gpe_en);
                default:     rsp_d.data = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_vld   = rsp_q.vld;
    assign rsp_err   = rsp_q.err;
    assign rsp_rdata = rsp_q.data;
    assign sci       = pm1_pend | gpe_pend;

endmodule

// File: rtl/acpi_evt_sci_chk.sv
module acpi_evt_sci_chk #(
    parameter int unsigned GPE_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_vld,
    input logic             bad,
    input logic             rsp_vld,
    input logic             rsp_err,
    input logic             ev_pwrbtn,
    input logic             ev_rtc,
    input logic             sci_en,
    input logic             sci,
    input logic             wr_pm1_sts,
    input logic [15:0]      pm1_sts,
    input logic [15:0]      pm1_en,
    input logic [GPE_W-1:0] gpe_en
);

    // R11: every request answered on the following cycle
    a_r11_rsp_next: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld |=> rsp_vld);

    // R11: no response without a request
    a_r11_rsp_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld |=> !rsp_vld);

    // R5: rejected access flags an error and keeps the enables
    a_r5_reject_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && bad) |=> (rsp_err && $stable(pm1_en) && $stable(gpe_en)));

    // R2: power button status stays set unless its register is written
    a_r2_pwrbtn_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (pm1_sts[8] && !wr_pm1_sts) |=> pm1_sts[8]);

    // R10: power button pulse dropped while interrupt mode is off
    a_r10_pwr_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_pwrbtn && !sci_en && !pm1_sts[8]) |=> !pm1_sts[8]);

    // R9: an RTC event is never lost to a same-cycle clear
    a_r9_rtc_kept: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rtc |=> pm1_sts[10]);

    // R8: no enables means no interrupt
    a_r8_sci_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (pm1_en == 16'h0 && gpe_en == '0) |-> !sci);

    // R8: enabled power button status raises the interrupt
    a_r8_sci_pwr: assert property (@(posedge clk) disable iff (!rst_n)
        (pm1_en[8] && pm1_sts[8]) |-> sci);

endmodule

bind acpi_evt_sci acpi_evt_sci_chk #(.GPE_W(GPE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_vld    (req_vld),
    .bad        (dec_bad),
    .rsp_vld    (rsp_vld),
    .rsp_err    (rsp_err),
    .ev_pwrbtn  (ev_pwrbtn),
    .ev_rtc     (ev_rtc),
    .sci_en     (sci_en),
    .sci        (sci),
    .wr_pm1_sts (wr_pm1_sts),
    .pm1_sts    (pm1_sts),
    .pm1_en     (pm1_en),
    .gpe_en     (gpe_en)
);

// File: tb/acpi_evt_sci_bench.sv
module acpi_evt_sci_bench;

    localparam logic [15:0] A_STS  = 16'h0400;
    localparam logic [15:0] A_EN   = 16'h0402;
    localparam logic [15:0] A_GSTS = 16'h0420;
    localparam logic [15:0] A_GEN  = 16'h0421;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_vld = 1'b0, req_wr = 1'b0;
    logic [15:0] req_addr = '0;
    logic [2:0]  req_size = '0;
    logic [15:0] req_wdata = '0;
    logic        rsp_vld, rsp_err;
    logic [15:0] rsp_rdata;
    logic        ev_tmr = 0, ev_bm = 0, ev_gbl = 0, ev_pwrbtn = 0;
    logic        ev_slpbtn = 0, ev_rtc = 0, ev_wak = 0;
    logic [7:0]  gpe_raise = '0;
    logic        sci_en = 1'b0;
    logic        sci;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    acpi_evt_sci u_acpi_evt_sci (
        .clk(clk), .rst_n(rst_n),
        .req_vld(req_vld), .req_wr(req_wr), .req_addr(req_addr),
        .req_size(req_size), .req_wdata(req_wdata),
        .rsp_vld(rsp_vld), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .ev_tmr(ev_tmr), .ev_bm(ev_bm), .ev_gbl(ev_gbl),
        .ev_pwrbtn(ev_pwrbtn), .ev_slpbtn(ev_slpbtn), .ev_rtc(ev_rtc),
        .ev_wak(ev_wak), .gpe_raise(gpe_raise), .sci_en(sci_en), .sci(sci)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one access; response sampled on the falling edge after the sampling edge
    task automatic access(input logic wr, input logic [15:0] a, input logic [2:0] sz,
                          input logic [15:0] wd, output logic [15:0] rd, output logic er);
        @(negedge clk);
        req_vld = 1'b1; req_wr = wr; req_addr = a; req_size = sz; req_wdata = wd;
        @(negedge clk);
        req_vld = 1'b0; req_wr = 1'b0;
        check("R11 rsp_vld", 32'(rsp_vld), 32'd1);
        rd = rsp_rdata;
        er = rsp_err;
    endtask

    task automatic wr_ok(input logic [15:0] a, input logic [2:0] sz, input logic [15:0] wd);
        logic [15:0] rd; logic er;
        access(1'b1, a, sz, wd, rd, er);
        check("R11 write accepted", 32'(er), 32'd0);
    endtask

    task automatic rd_chk(input string req, input logic [15:0] a, input logic [2:0] sz,
                          input logic [15:0] mask, input logic [15:0] exp);
        logic [15:0] rd; logic er;
        access(1'b0, a, sz, 16'h0, rd, er);
        check(req, 32'(rd & mask), 32'(exp));
    endtask

    task automatic pulse_gpe(input logic [7:0] v);
        @(negedge clk); gpe_raise = v;
        @(negedge clk); gpe_raise = '0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1 rsp_vld idle", 32'(rsp_vld), 32'd0);
        check("R1 sci low", 32'(sci), 32'd0);
        rd_chk("R1 status", A_STS, 3'd2, 16'hFFFF, 16'h0000);
        rd_chk("R1 enable", A_EN, 3'd2, 16'hFFFF, 16'h0000);
        rd_chk("R1 gpe status", A_GSTS, 3'd1, 16'hFFFF, 16'h0000);
        rd_chk("R1 gpe enable", A_GEN, 3'd1, 16'hFFFF, 16'h0000);
    endtask

    task automatic t_events;
        sci_en = 1'b1;
        @(negedge clk);
        {ev_tmr, ev_bm, ev_gbl, ev_pwrbtn, ev_slpbtn, ev_rtc, ev_wak} = 7'h7F;
        @(negedge clk);
        {ev_tmr, ev_bm, ev_gbl, ev_pwrbtn, ev_slpbtn, ev_rtc, ev_wak} = 7'h00;
        check("R8 sci low with no enables", 32'(sci), 32'd0);
        repeat (3) @(negedge clk);
        rd_chk("R2 sticky status bits", A_STS, 3'd2, 16'hFFFF, 16'h8731);
    endtask

    task automatic t_w1c;
        wr_ok(A_STS, 3'd2, 16'h0000);
        rd_chk("R3 zero write keeps", A_STS, 3'd2, 16'hFFFF, 16'h8731);
        wr_ok(A_STS, 3'd2, 16'hFFFF);
        rd_chk("R3 only clearable bits cleared", A_STS, 3'd2, 16'hFFFF, 16'h0021);
    endtask

    task automatic t_enable;
        wr_ok(A_EN, 3'd2, 16'hFFFF);
        rd_chk("R4 writable enables", A_EN, 3'd2, 16'hFFFF, 16'h0520);
        check("R8 sci from global lock", 32'(sci), 32'd1);
        wr_ok(A_EN, 3'd2, 16'h0000);
        check("R8 sci drops after disable", 32'(sci), 32'd0);
    endtask

    task automatic t_size;
        logic [15:0] rd; logic er;
        access(1'b1, A_EN, 3'd1, 16'hFFFF, rd, er);
        check("R5 byte write to enable rejected", 32'(er), 32'd1);
        rd_chk("R5 enable unchanged", A_EN, 3'd2, 16'hFFFF, 16'h0000);
        access(1'b0, A_STS, 3'd4, 16'h0, rd, er);
        check("R5 dword read rejected", 32'(er), 32'd1);
        access(1'b0, 16'h0404, 3'd2, 16'h0, rd, er);
        check("R11 unmapped address error", 32'(er), 32'd1);
        access(1'b1, A_GEN, 3'd2, 16'h00FF, rd, er);
        check("R6 word write to gpe rejected", 32'(er), 32'd1);
        rd_chk("R6 gpe enable unchanged", A_GEN, 3'd1, 16'hFFFF, 16'h0000);
    endtask

    task automatic t_power;
        sci_en = 1'b0;
        @(negedge clk); ev_pwrbtn = 1'b1;
        @(negedge clk); ev_pwrbtn = 1'b0;
        rd_chk("R10 pulse dropped while off", A_STS, 3'd2, 16'h0100, 16'h0000);
        sci_en = 1'b1;
        @(negedge clk); ev_pwrbtn = 1'b1;
        @(negedge clk); ev_pwrbtn = 1'b0;
        rd_chk("R10 pulse accepted while on", A_STS, 3'd2, 16'h0100, 16'h0100);
        wr_ok(A_EN, 3'd2, 16'h0100);
        check("R8 sci from power button", 32'(sci), 32'd1);
        wr_ok(A_STS, 3'd2, 16'h0100);
        check("R8 sci after clear", 32'(sci), 32'd0);
        rd_chk("R3 power bit cleared", A_STS, 3'd2, 16'h0100, 16'h0000);
        wr_ok(A_EN, 3'd2, 16'h0000);
    endtask

    task automatic t_gpe;
        wr_ok(A_GEN, 3'd1, 16'h00FF);
        rd_chk("R6 gpe enable masked", A_GEN, 3'd1, 16'hFFFF, 16'h0001);
        pulse_gpe(8'h08);
        rd_chk("R7 invalid raise ignored", A_GSTS, 3'd1, 16'hFFFF, 16'h0000);
        check("R8 sci low after invalid raise", 32'(sci), 32'd0);
        pulse_gpe(8'h01);
        check("R8 sci from gpe", 32'(sci), 32'd1);
        rd_chk("R7 valid raise sets", A_GSTS, 3'd1, 16'hFFFF, 16'h0001);
        wr_ok(A_GSTS, 3'd1, 16'h00FE);
        rd_chk("R6 other bits do not clear", A_GSTS, 3'd1, 16'hFFFF, 16'h0001);
        wr_ok(A_GSTS, 3'd1, 16'h0001);
        rd_chk("R6 gpe w1c", A_GSTS, 3'd1, 16'hFFFF, 16'h0000);
        check("R8 sci low after gpe clear", 32'(sci), 32'd0);
    endtask

    task automatic t_race;
        @(negedge clk); ev_rtc = 1'b1;
        @(negedge clk); ev_rtc = 1'b0;
        rd_chk("R2 rtc set", A_STS, 3'd2, 16'h0400, 16'h0400);
        @(negedge clk);
        req_vld = 1'b1; req_wr = 1'b1; req_addr = A_STS; req_size = 3'd2;
        req_wdata = 16'h0400; ev_rtc = 1'b1;
        @(negedge clk);
        req_vld = 1'b0; req_wr = 1'b0; ev_rtc = 1'b0;
        rd_chk("R9 event beats clear", A_STS, 3'd2, 16'h0400, 16'h0400);
        wr_ok(A_STS, 3'd2, 16'h0400);
        rd_chk("R3 rtc cleared", A_STS, 3'd2, 16'h0400, 16'h0000);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_events();
        t_w1c();
        t_enable();
        t_size();
        t_power();
        t_gpe();
        t_race();
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule